// File: doc/BRIEF.md
# Multi-Lane Serial Audio Port

This block is a frame-synchronous serial audio port with eight output lanes and eight input lanes. Each lane carries one stereo pair, so sixteen channels travel each way. From the master clock it derives three timing signals: an oversampling clock at a quarter of the master rate, a bit clock at one sixteenth of it, and a word-select line. A frame is 64 bit-clock periods long and splits into a left and a right 32-bit slot.

Outgoing samples are 22 bits wide and are taken from a parallel bus. Incoming samples are cut to 20 bits and placed on a parallel bus. A one-cycle frame strobe marks the frame boundary. At the clock edge that ends the strobe cycle, all sixteen outgoing samples are latched and all sixteen captured samples are published together.

A format input selects one of two framings:

- **Standard I2S:** the left slot has word select low, the sample starts one bit after the word-select edge, and the tail of the slot is zero-filled.
- **Right-justified:** the left slot has word select high, and the sample ends on the last bit of its slot with sign bits in front.

Top module: `aud_serial_port`

## Requirements
- R1: `bck_o` runs at 1/16 of the master clock with 8 cycles high and 8 low. `ovck_o` runs at 1/4 of the master clock with 2 cycles high and 2 low.
- R2: `frame_stb_o` is high for exactly one master cycle in every 1024 (64 bit periods of 16 cycles), provided `fmt_i` is steady.
- R3: `ws_o` and every bit of `sd_o` change only on the master edge where `bck_o` falls. `sd_i` is sampled on the master edge where `bck_o` rises.
- R4: With `fmt_i`=0 (I2S), `ws_o` is low for 32 periods (left) and high for 32 periods (right). It falls at the edge that ends the strobe cycle, one period before the first left data bit.
- R5: With `fmt_i`=0, the 22-bit sample of each slot goes out MSB first, beginning one bit period after the word-select edge. The 10 remaining bits of the slot are 0.
- R6: With `fmt_i`=1 (right-justified), `ws_o` is high for the 32 periods of the left slot and low for the right slot. It rises at the edge that ends the strobe cycle, together with the first left data bit.
- R7: With `fmt_i`=1, each slot carries the 22-bit sample sign-extended to 32 bits, MSB first, so the sample LSB is the last bit of the slot.
- R8: `tx_smp_i` is sampled only at the edge that ends a strobe cycle. Values it holds in any other cycle have no effect on `sd_o`.
- R9: With `fmt_i`=0, a captured channel is the first 20 bits of its slot, MSB first (slot bits 31..12). The last 12 bits of the slot are discarded.
- R10: With `fmt_i`=1, a captured channel is the last 20 bits of its slot (slot bits 19..0). The first 12 bits are discarded.
- R11: `rx_smp_o` changes only at the edge that ends a strobe cycle. At that edge all 16 channels are updated from the frame that just ended.
- R12: Channel c = 2*L + s, where L is the lane and s is 0 for left and 1 for right. It occupies `tx_smp_i[c*22 +: 22]` and `rx_smp_o[c*20 +: 20]`.
- R13: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, 1024 times the sample rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_i | input | 1 | Framing select: 0 = I2S, 1 = right-justified |
| tx_smp_i | input | 352 | Sixteen 22-bit outgoing samples, channel c at [c*22 +: 22] |
| rx_smp_o | output | 320 | Sixteen 20-bit captured samples, channel c at [c*20 +: 20] |
| frame_stb_o | output | 1 | One-cycle frame strobe; latch/publish at the edge ending it |
| ovck_o | output | 1 | Oversampling clock, 256 times the sample rate |
| bck_o | output | 1 | Bit clock, 64 times the sample rate |
| ws_o | output | 1 | Word select |
| sd_o | output | 8 | Serial data out, one bit per lane |
| sd_i | input | 8 | Serial data in, one bit per lane |

## Verification
The checks on frame spacing and on word-select direction at the strobe assume that `fmt_i` changes only while reset is held. A change mid-frame would move the strobe point and break the 1024-cycle spacing. The bench therefore switches format only under reset.

The bench drives `sd_i` on the cycle after it sees `bck_o` fall, so the value is settled well before the rising edge that samples it. It keeps `tx_smp_i` valid only during the strobe cycle and scrambles it on the next cycle, so any read outside the latch point would show up on `sd_o`.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;
  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } fmt_e;
endpackage

// File: rtl/aud_sp_rst_sync.sv
module aud_sp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/aud_sp_timing.sv
module aud_sp_timing #(
  parameter int unsigned SLOT_W  = 32,
  parameter int unsigned BCK_DIV = 16,
  parameter int unsigned OVS_DIV = 4,
  localparam int unsigned PH_W   = $clog2(BCK_DIV),
  localparam int unsigned PER_W  = $clog2(2 * SLOT_W),
  localparam int unsigned K_W    = $clog2(SLOT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rj_i,
  output logic             bck_o,
  output logic             ovck_o,
  output logic             ws_o,
  output logic             stb_o,
  output logic             adv_o,
  output logic             smp_en_o,
  output logic             nxt_side_o,
  output logic [K_W-1:0]   nxt_k_o,
  output logic             cur_side_o,
  output logic [K_W-1:0]   cur_k_o
);
  localparam int unsigned OVS_BIT  = $clog2(OVS_DIV) - 1;
  localparam int unsigned LAST_PER = 2 * SLOT_W - 1;

  logic [PH_W-1:0]  ph_q, ph_d;
  logic [PER_W-1:0] per_q, per_d, per_n;
  logic             ws_q, ws_d, ws_nxt, adv;

  // next-state
  always_comb begin
    adv   = (ph_q == PH_W'(BCK_DIV - 1));
    per_n = (per_q == PER_W'(LAST_PER)) ? '0 : per_q + PER_W'(1);
    if (rj_i) ws_nxt = (per_n < PER_W'(SLOT_W));
    else      ws_nxt = (per_n >= PER_W'(SLOT_W - 1)) && (per_n != PER_W'(LAST_PER));
    ph_d  = adv ? '0 : ph_q + PH_W'(1);
    per_d = adv ? per_n : per_q;
    ws_d  = adv ? ws_nxt : ws_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      per_q <= '0;
      ws_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      per_q <= per_d;
      ws_q  <= ws_d;
    end
  end

  assign adv_o      = adv;
  assign smp_en_o   = (ph_q == PH_W'(BCK_DIV / 2 - 1));
  assign stb_o      = adv && (per_q == (rj_i ? PER_W'(LAST_PER) : PER_W'(LAST_PER - 1)));
  assign bck_o      = ph_q[PH_W-1];
  assign ovck_o     = ph_q[OVS_BIT];
  assign ws_o       = ws_q;
  assign nxt_side_o = per_n[PER_W-1];
  assign nxt_k_o    = per_n[K_W-1:0];
  assign cur_side_o = per_q[PER_W-1];
  assign cur_k_o    = per_q[K_W-1:0];
endmodule

// File: rtl/aud_sp_tx_lane.sv
module aud_sp_tx_lane #(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned TX_W   = 22,
  localparam int unsigned K_W   = $clog2(SLOT_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic            rj_i,
  input  logic            side_i,
  input  logic [K_W-1:0]  k_i,
  input  logic [TX_W-1:0] smp_l_i,
  input  logic [TX_W-1:0] smp_r_i,
  output logic            sd_o
);
  localparam int unsigned PAD_W = SLOT_W - TX_W;

  logic [TX_W-1:0]   hold_l_q, hold_l_d, hold_r_q, hold_r_d, sel;
  logic [SLOT_W-1:0] word;
  logic              sd_q, sd_d;

  // next-state: the slot word is built from the next hold value, so the
  // first bit after a latch already carries the new sample
  always_comb begin
    hold_l_d = load_i ? smp_l_i : hold_l_q;
    hold_r_d = load_i ? smp_r_i : hold_r_q;
    sel      = side_i ? hold_r_d : hold_l_d;
    if (rj_i) word = {{PAD_W{sel[TX_W-1]}}, sel};
    else      word = {sel, {PAD_W{1'b0}}};
    sd_d     = adv_i ? word[K_W'(SLOT_W - 1) - k_i] : sd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      sd_q     <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      sd_q     <= sd_d;
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/aud_sp_rx_lane.sv
module aud_sp_rx_lane #(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned RX_W   = 20,
  localparam int unsigned K_W   = $clog2(SLOT_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            smp_en_i,
  input  logic            pub_i,
  input  logic            rj_i,
  input  logic            side_i,
  input  logic [K_W-1:0]  k_i,
  input  logic            sd_i,
  output logic [RX_W-1:0] smp_l_o,
  output logic [RX_W-1:0] smp_r_o
);
  logic [RX_W-1:0] acc_l_q, acc_l_d, acc_r_q, acc_r_d;
  logic [RX_W-1:0] out_l_q, out_l_d, out_r_q, out_r_d;
  logic            in_win;

  always_comb begin
    in_win  = rj_i ? (k_i >= K_W'(SLOT_W - RX_W)) : (k_i < K_W'(RX_W));
    acc_l_d = acc_l_q;
    acc_r_d = acc_r_q;
    if (smp_en_i && in_win) begin
      if (side_i) acc_r_d = {acc_r_q[RX_W-2:0], sd_i};
      else        acc_l_d = {acc_l_q[RX_W-2:0], sd_i};
    end
    out_l_d = pub_i ? acc_l_q : out_l_q;
    out_r_d = pub_i ? acc_r_q : out_r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_l_q <= '0;
      acc_r_q <= '0;
      out_l_q <= '0;
      out_r_q <= '0;
    end else begin
      acc_l_q <= acc_l_d;
      acc_r_q <= acc_r_d;
      out_l_q <= out_l_d;
      out_r_q <= out_r_d;
    end
  end

  assign smp_l_o = out_l_q;
  assign smp_r_o = out_r_q;
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_sp_pkg::*;
#(
  parameter int unsigned LANES   = 8,
  parameter int unsigned SLOT_W  = 32,
  parameter int unsigned TX_W    = 22,
  parameter int unsigned RX_W    = 20,
  parameter int unsigned BCK_DIV = 16,
  parameter int unsigned OVS_DIV = 4,
  localparam int unsigned CH     = 2 * LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fmt_i,
  input  logic [CH*TX_W-1:0] tx_smp_i,
  output logic [CH*RX_W-1:0] rx_smp_o,
  output logic               frame_stb_o,
  output logic               ovck_o,
  output logic               bck_o,
  output logic               ws_o,
  output logic [LANES-1:0]   sd_o,
  input  logic [LANES-1:0]   sd_i
);
  localparam int unsigned K_W = $clog2(SLOT_W);

  logic           rst_n_s, rj, stb, adv, smp_en;
  logic           nxt_side, cur_side;
  logic [K_W-1:0] nxt_k, cur_k;

  assign rj = (fmt_i == FMT_RJ);

  aud_sp_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  aud_sp_timing #(.SLOT_W(SLOT_W), .BCK_DIV(BCK_DIV), .OVS_DIV(OVS_DIV)) u_tim (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .rj_i       (rj),
    .bck_o      (bck_o),
    .ovck_o     (ovck_o),
    .ws_o       (ws_o),
    .stb_o      (stb),
    .adv_o      (adv),
    .smp_en_o   (smp_en),
    .nxt_side_o (nxt_side),
    .nxt_k_o    (nxt_k),
    .cur_side_o (cur_side),
    .cur_k_o    (cur_k)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aud_sp_tx_lane #(.SLOT_W(SLOT_W), .TX_W(TX_W)) u_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_s),
      .load_i  (stb),
      .adv_i   (adv),
      .rj_i    (rj),
      .side_i  (nxt_side),
      .k_i     (nxt_k),
      .smp_l_i (tx_smp_i[(2*g)*TX_W +: TX_W]),
      .smp_r_i (tx_smp_i[(2*g+1)*TX_W +: TX_W]),
      .sd_o    (sd_o[g])
    );

    aud_sp_rx_lane #(.SLOT_W(SLOT_W), .RX_W(RX_W)) u_rx (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_s),
      .smp_en_i (smp_en),
      .pub_i    (stb),
      .rj_i     (rj),
      .side_i   (cur_side),
      .k_i      (cur_k),
      .sd_i     (sd_i[g]),
      .smp_l_o  (rx_smp_o[(2*g)*RX_W +: RX_W]),
      .smp_r_o  (rx_smp_o[(2*g+1)*RX_W +: RX_W])
    );
  end

  assign frame_stb_o = stb;
endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned SLOT_W  = 32,
  parameter int unsigned BCK_DIV = 16,
  parameter int unsigned OVS_DIV = 4,
  parameter int unsigned RX_BITS = 320
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fmt_i,
  input logic               bck_o,
  input logic               ovck_o,
  input logic               ws_o,
  input logic [LANES-1:0]   sd_o,
  input logic               frame_stb_o,
  input logic [RX_BITS-1:0] rx_smp_o
);
  localparam int unsigned FRAME = 2 * SLOT_W * BCK_DIV;

  logic        bck_prev, bck_seen, ovck_prev, ovck_seen, stb_seen;
  logic [7:0]  bck_run, ovck_run;
  logic [15:0] stb_gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_prev  <= 1'b0;
      bck_seen  <= 1'b0;
      bck_run   <= '0;
      ovck_prev <= 1'b0;
      ovck_seen <= 1'b0;
      ovck_run  <= '0;
      stb_seen  <= 1'b0;
      stb_gap   <= '0;
    end else begin
      bck_prev  <= bck_o;
      ovck_prev <= ovck_o;
      if (bck_o != bck_prev) begin bck_run <= '0; bck_seen <= 1'b1; end
      else bck_run <= bck_run + 8'd1;
      if (ovck_o != ovck_prev) begin ovck_run <= '0; ovck_seen <= 1'b1; end
      else ovck_run <= ovck_run + 8'd1;
      if (frame_stb_o) begin stb_gap <= '0; stb_seen <= 1'b1; end
      else stb_gap <= stb_gap + 16'd1;
    end
  end

  p_bck_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bck_seen && bck_o != bck_prev) |-> bck_run == 8'(BCK_DIV / 2 - 1));

  p_ovck_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovck_seen && ovck_o != ovck_prev) |-> ovck_run == 8'(OVS_DIV / 2 - 1));

  p_stb_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |=> !frame_stb_o);

  p_stb_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_o && stb_seen) |-> stb_gap == 16'(FRAME - 1));

  p_edge_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ws_o) || !$stable(sd_o)) |-> $fell(bck_o));

  p_ws_left_i2s_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_o && !fmt_i) |=> $fell(ws_o));

  p_ws_left_rj_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_o && fmt_i) |=> $rose(ws_o));

  p_rx_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_smp_o) |-> $past(frame_stb_o));
endmodule

bind aud_serial_port aud_serial_port_chk #(
  .LANES(LANES), .SLOT_W(SLOT_W), .BCK_DIV(BCK_DIV), .OVS_DIV(OVS_DIV),
  .RX_BITS(CH * RX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fmt_i       (fmt_i),
  .bck_o       (bck_o),
  .ovck_o      (ovck_o),
  .ws_o        (ws_o),
  .sd_o        (sd_o),
  .frame_stb_o (frame_stb_o),
  .rx_smp_o    (rx_smp_o)
);

// File: tb/aud_serial_port_bench.sv
module aud_serial_port_bench;
  localparam int LANES = 8;
  localparam int CH    = 16;
  localparam int TXW   = 22;
  localparam int RXW   = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n, fmt, stb, ovck, bck, ws;
  logic [CH*TXW-1:0]  tx_smp;
  logic [CH*RXW-1:0]  rx_smp;
  logic [LANES-1:0]   sd_out, sd_in;

  aud_serial_port u_aud_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .tx_smp_i(tx_smp),
    .rx_smp_o(rx_smp), .frame_stb_o(stb), .ovck_o(ovck), .bck_o(bck),
    .ws_o(ws), .sd_o(sd_out), .sd_i(sd_in)
  );

  int n_run, n_fail;
  bit done;

  logic [TXW-1:0] cur_tx [CH];
  logic [31:0]    cur_rw [CH];
  logic [RXW-1:0] exp_rx [CH];
  bit have_tx, drv_on, stb_seen, bck_seen, ovck_seen, rx_valid, pend_rx, scramble;
  bit prev_bck, prev_ovck, prev_ws;
  logic [LANES-1:0] prev_sd;
  int cyc, r, nextp, nstb, last_stb, last_bck, last_ovck;

  function automatic bit exp_sd(bit rjf, logic [TXW-1:0] s, int k);
    logic [31:0] w;
    w = rjf ? {{10{s[TXW-1]}}, s} : {s, 10'b0};
    return w[31-k];
  endfunction

  function automatic bit exp_ws(bit rjf, int p);
    return rjf ? (p < 32) : (p >= 31 && p != 63);
  endfunction

  function automatic logic [RXW-1:0] rx_take(bit rjf, logic [31:0] w);
    return rjf ? w[19:0] : w[31:12];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic reset_check();
    // R13: every output low while reset is held
    check(bck == 0 && ovck == 0 && ws == 0 && stb == 0, "R13 clocks", {bck, ovck, ws, stb}, 0);
    check(sd_out == 0, "R13 sd", 32'(sd_out), 0);
    check(rx_smp == 0, "R13 rx", 32'(rx_smp[31:0] | rx_smp[CH*RXW-1 -: 32]), 0);
  endtask

  task automatic clear_state();
    have_tx = 0; drv_on = 0; stb_seen = 0; bck_seen = 0; ovck_seen = 0;
    rx_valid = 0; pend_rx = 0; scramble = 0; nstb = 0; r = 0; nextp = 0;
    prev_bck = 0; prev_ovck = 0; prev_ws = 0; prev_sd = '0;
  endtask

  task automatic step();
    int p;
    cyc++;
    // R3: serial outputs move only when the bit clock has just fallen
    if (ws != prev_ws || sd_out != prev_sd)
      check(!bck && prev_bck, "R3 edge", {bck, prev_bck}, 32'b01);
    // R1: oversampling clock period
    if (ovck && !prev_ovck) begin
      if (ovck_seen) check(cyc - last_ovck == 4, "R1 ovck", 32'(cyc - last_ovck), 4);
      ovck_seen = 1; last_ovck = cyc;
    end
    // bit clock rise: period and serial data
    if (bck && !prev_bck) begin
      if (bck_seen) check(cyc - last_bck == 16, "R1 bck", 32'(cyc - last_bck), 16);
      bck_seen = 1; last_bck = cyc;
      if (have_tx) begin
        p = fmt ? r : ((r == 0) ? 63 : r - 1);
        check(ws == exp_ws(fmt, p), fmt ? "R6 ws" : "R4 ws", 32'(ws), 32'(exp_ws(fmt, p)));
        for (int l = 0; l < LANES; l++) begin
          automatic int c = 2*l + p/32;
          automatic bit e = exp_sd(fmt, cur_tx[c], p % 32);
          check(sd_out[l] == e, fmt ? "R7 R8 R12 sd" : "R5 R8 R12 sd", 32'(sd_out[l]), 32'(e));
        end
        if (r == 32 && rx_valid)
          for (int c = 0; c < CH; c++)
            check(rx_smp[c*RXW +: RXW] == exp_rx[c], "R11 hold", 32'(rx_smp[c*RXW +: RXW]), 32'(exp_rx[c]));
        r++;
      end
    end
    // bit clock fall: present the next input bit
    if (!bck && prev_bck && drv_on) begin
      for (int l = 0; l < LANES; l++) begin
        automatic int c = 2*l + nextp/32;
        sd_in[l] = cur_rw[c][31 - nextp % 32];
      end
      nextp = (nextp + 1) % 64;
    end
    // published captures, one cycle after the strobe
    if (pend_rx) begin
      for (int c = 0; c < CH; c++)
        check(rx_smp[c*RXW +: RXW] == exp_rx[c], fmt ? "R10 R11 R12 rx" : "R9 R11 R12 rx",
              32'(rx_smp[c*RXW +: RXW]), 32'(exp_rx[c]));
      pend_rx = 0; rx_valid = 1;
    end
    if (stb) begin
      if (stb_seen) check(cyc - last_stb == 1024, "R2 gap", 32'(cyc - last_stb), 1024);
      stb_seen = 1; last_stb = cyc;
      if (nstb >= 1) begin
        for (int c = 0; c < CH; c++) exp_rx[c] = rx_take(fmt, cur_rw[c]);
        pend_rx = 1;
      end
      for (int c = 0; c < CH; c++) begin
        if (nstb == 2) begin
          case (c % 4)
            0: cur_tx[c] = 22'h1FFFFF;
            1: cur_tx[c] = 22'h200000;
            2: cur_tx[c] = 22'h3FFFFF;
            default: cur_tx[c] = 22'h000001;
          endcase
        end else cur_tx[c] = TXW'($urandom);
        tx_smp[c*TXW +: TXW] = cur_tx[c];
        if (nstb == 3) cur_rw[c] = (c % 2 == 1) ? 32'hFFF0_0000 : 32'h000F_FFFF;
        else           cur_rw[c] = $urandom;
      end
      have_tx = 1; r = 0; drv_on = 1; scramble = 1;
      nextp = fmt ? 0 : 63;
      nstb++;
    end else if (scramble) begin
      // R8: junk outside the strobe cycle must not reach the serial stream
      for (int c = 0; c < CH; c++) tx_smp[c*TXW +: TXW] = TXW'($urandom);
      scramble = 0;
    end
    prev_bck = bck; prev_ovck = ovck; prev_ws = ws; prev_sd = sd_out;
  endtask

  task automatic run_frames(input int n);
    while (nstb < n) begin
      @(negedge clk);
      step();
    end
    repeat (40) begin @(negedge clk); step(); end
  endtask

  initial begin
    void'($urandom(32'd2718));
    n_run = 0; n_fail = 0; cyc = 0; done = 0;
    rst_n = 0; fmt = 0; sd_in = '0; tx_smp = '0;
    clear_state();
    repeat (5) @(negedge clk);
    reset_check();
    rst_n = 1;
    run_frames(10);
    rst_n = 0; fmt = 1; sd_in = '0;
    clear_state();
    repeat (5) @(negedge clk);
    reset_check();
    rst_n = 1;
    run_frames(10);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule